// File: doc/BRIEF.md
# Addressable Asynchronous Serial Receiver

This block turns an asynchronous serial line into a stream of received characters. It waits for a start bit, then shifts in eight or nine data bits with the least significant bit first, and finally checks the stop bit. The line is sampled on an external tick that arrives sixteen times per bit period. Each bit is decided by a majority vote of three samples taken around the middle of the bit. A start bit that does not survive to its middle is treated as a glitch and dropped.

Finished characters go into a two-entry receive queue. A third character can be assembling in the shift register at the same time. The host reads the oldest character with a one-cycle pop strobe. Each entry carries its data byte, the ninth bit, and a framing-error bit. In nine-bit mode an address filter can be switched on. While it is on, a character is kept only when its ninth bit is 1.

If a character completes while the queue is full, that character is lost and a sticky overrun flag is raised. While the flag is set, reception into the queue stops. The only way to clear the flag is to take the receiver enable low. Reception does not depend on any transmitter or on host activity.

Top module: `addr_serial_rx`

## Requirements
- R1: In 8-bit mode a frame of one low start bit, eight data bits sent least significant first, and a stop bit is delivered on `rd_data`, with `rd_bit9` reading 0.
- R2: In 9-bit mode the bit that follows the eight data bits is delivered on `rd_bit9`.
- R3: With `nine_bit`=1 and `addr_only`=1, a character whose ninth bit is 0 is discarded and does not raise `data_ready`. In 8-bit mode `addr_only` has no effect.
- R4: The queue holds up to two characters and hands them out oldest first.
- R5: A character kept by the filter that completes while both entries are full is lost and sets `overrun`. While `overrun` is 1, no character is written into the queue.
- R6: `overrun` stays at 1 until `rx_en` is low for a cycle, and that clears it. Characters already in the queue are kept.
- R7: A stop bit sampled low gives that character `rd_ferr`=1. A high stop bit gives `rd_ferr`=0.
- R8: `data_ready` is 1 exactly while the queue is non-empty. `rd_pop` removes the head entry, and a pop while the queue is empty has no effect.
- R9: A low pulse on `rxd` that is shorter than half a bit period is not taken as a start bit, and no character results from it.
- R10: After reset, `data_ready` and `overrun` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_en | input | 1 | Receiver enable; low clears the overrun flag and the frame state |
| nine_bit | input | 1 | 1 selects nine data bits per character |
| addr_only | input | 1 | In 9-bit mode, keep only characters whose ninth bit is 1 |
| tick | input | 1 | One-cycle sample strobe, 16 per bit period |
| rxd | input | 1 | Serial input line, idle high |
| rd_pop | input | 1 | Pops the head entry of the queue |
| rd_data | output | 8 | Data byte of the head entry |
| rd_bit9 | output | 1 | Ninth bit of the head entry |
| rd_ferr | output | 1 | Framing-error bit of the head entry |
| data_ready | output | 1 | Queue is not empty |
| overrun | output | 1 | Sticky overrun flag |

## Verification
Some rules are checked by the assertions on every cycle. The frame state moves only on a tick. Nothing is written while overrun is set, and the overrun flag holds until the enable drops. Filtered data characters never reach the queue. The queue is never written past full, and a pop on an empty queue leaves it empty. Other behaviour can only be shown by the bench's scenarios, because it depends on whole frames. That covers bit order and majority sampling, the ninth-bit and framing-error values, glitch rejection, oldest-first order, and which character is lost on an overrun.

// File: rtl/uarx_pkg.sv
package uarx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_STOP
    } rx_state_t;

    typedef struct packed {
        logic       ferr;
        logic       b9;
        logic [7:0] data;
    } rx_char_t;

endpackage

// File: rtl/uarx_sync.sv
module uarx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '1;
        else        sh_q <= sh_d;
    end

    assign dout = sh_q[STAGES-1];
endmodule

// File: rtl/uarx_frame.sv
module uarx_frame
    import uarx_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     en,
    input  logic     nine,
    input  logic     tick,
    input  logic     rx,
    output logic     done,
    output rx_char_t ch
);
    localparam int CW  = $clog2(OSR);
    localparam int MID = OSR / 2 + 1;

    typedef struct packed {
        rx_state_t st;
        logic [CW-1:0] cnt;
        logic [3:0]    bitn;
        logic [1:0]    win;
        logic [8:0]    sh;
        logic          done;
        rx_char_t      ch;
    } frame_regs_t;

    frame_regs_t r_d, r_q;
    logic vote, at_mid, at_end;
    logic [3:0] last_idx;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        vote     = (r_q.win[1] & r_q.win[0]) | (r_q.win[1] & rx) | (r_q.win[0] & rx);
        at_mid   = (r_q.cnt == CW'(MID));
        at_end   = (r_q.cnt == CW'(OSR - 1));
        last_idx = nine ? 4'd8 : 4'd7;
        if (!en) begin
            r_d.st   = ST_IDLE;
            r_d.cnt  = '0;
            r_d.bitn = '0;
        end else if (tick) begin
            r_d.win = {r_q.win[0], rx};
            r_d.cnt = r_q.cnt + CW'(1);
            case (r_q.st)
                ST_IDLE: begin
                    if (!rx) begin
                        r_d.st  = ST_START;
                        r_d.cnt = CW'(1);
                    end else begin
                        r_d.cnt = '0;
                    end
                end
                ST_START: begin
                    if (at_mid && vote) begin
                        r_d.st  = ST_IDLE;
                        r_d.cnt = '0;
                    end else if (at_end) begin
                        r_d.st   = ST_DATA;
                        r_d.cnt  = '0;
                        r_d.bitn = '0;
                    end
                end
                ST_DATA: begin
                    if (at_mid) r_d.sh[r_q.bitn] = vote;
                    if (at_end) begin
                        r_d.cnt = '0;
                        if (r_q.bitn == last_idx) r_d.st = ST_STOP;
                        else                      r_d.bitn = r_q.bitn + 4'd1;
                    end
                end
                ST_STOP: begin
                    if (at_mid) begin
                        r_d.done    = 1'b1;
                        r_d.ch.data = r_q.sh[7:0];
                        r_d.ch.b9   = nine & r_q.sh[8];
                        r_d.ch.ferr = ~vote;
                        r_d.st      = ST_IDLE;
                        r_d.cnt     = '0;
                    end
                end
                default: r_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q     <= '0;
            r_q.st  <= ST_IDLE;
            r_q.win <= 2'b11;
        end else begin
            r_q <= r_d;
        end
    end

    assign done = r_q.done;
    assign ch   = r_q.ch;

    // R9: the frame state advances only on a sample tick
    p_hold_no_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !tick) |=> $stable(r_q.st));

    // R7: a finished character always comes out of the stop-bit check
    p_done_from_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.done |-> ($past(r_q.st) == ST_STOP && r_q.st == ST_IDLE));
endmodule

// File: rtl/uarx_fifo.sv
module uarx_fifo
    import uarx_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     wr,
    input  rx_char_t wdata,
    input  logic     rd,
    output rx_char_t rdata,
    output logic     empty,
    output logic     full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        rx_char_t [DEPTH-1:0] mem;
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } fifo_regs_t;

    fifo_regs_t f_d, f_q;
    logic rd_ok;

    always_comb begin
        f_d   = f_q;
        rd_ok = rd && (f_q.cnt != '0);
        if (wr) begin
            f_d.mem[f_q.wp] = wdata;
            f_d.wp = (f_q.wp == AW'(DEPTH - 1)) ? '0 : f_q.wp + AW'(1);
        end
        if (rd_ok) begin
            f_d.rp = (f_q.rp == AW'(DEPTH - 1)) ? '0 : f_q.rp + AW'(1);
        end
        case ({wr, rd_ok})
            2'b10:   f_d.cnt = f_q.cnt + CW'(1);
            2'b01:   f_d.cnt = f_q.cnt - CW'(1);
            default: f_d.cnt = f_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign rdata = f_q.mem[f_q.rp];
    assign empty = (f_q.cnt == '0);
    assign full  = (f_q.cnt == CW'(DEPTH));

    // R4: never written while full unless the head leaves in the same cycle
    p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && full) |-> rd);

    // R8: a pop on an empty queue leaves it empty
    p_pop_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && empty && !wr) |=> empty);

    // R8: popping the last entry drops data-ready
    p_last_pop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && f_q.cnt == CW'(1) && !wr) |=> empty);
endmodule

// File: rtl/addr_serial_rx.sv
module addr_serial_rx
    import uarx_pkg::*;
#(
    parameter int OSR   = 16,
    parameter int DEPTH = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_en,
    input  logic       nine_bit,
    input  logic       addr_only,
    input  logic       tick,
    input  logic       rxd,
    input  logic       rd_pop,
    output logic [7:0] rd_data,
    output logic       rd_bit9,
    output logic       rd_ferr,
    output logic       data_ready,
    output logic       overrun
);
    logic     rx_s, done, keep, space, wr, empty, full;
    logic     ovr_d, ovr_q;
    rx_char_t ch, head;

    uarx_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(rxd), .dout(rx_s)
    );

    uarx_frame #(.OSR(OSR)) u_frame (
        .clk(clk), .rst_n(rst_n), .en(rx_en), .nine(nine_bit),
        .tick(tick), .rx(rx_s), .done(done), .ch(ch)
    );

    always_comb begin
        keep  = !(nine_bit && addr_only && !ch.b9);
        space = !full || rd_pop;
        wr    = done && keep && !ovr_q && space;
        ovr_d = ovr_q;
        if (!rx_en)                          ovr_d = 1'b0;
        else if (done && keep && !ovr_q && !space) ovr_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ovr_q <= 1'b0;
        else        ovr_q <= ovr_d;
    end

    uarx_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .wr(wr), .wdata(ch),
        .rd(rd_pop), .rdata(head), .empty(empty), .full(full)
    );

    assign rd_data    = head.data;
    assign rd_bit9    = head.b9;
    assign rd_ferr    = head.ferr;
    assign data_ready = !empty;
    assign overrun    = ovr_q;

    // R3: data characters in address mode never reach the queue
    p_filter_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && nine_bit && addr_only && !ch.b9) |-> !wr);

    // R5: no writes while the overrun flag is set
    p_no_write_in_ovr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |-> !wr);

    // R6: the flag holds while enabled
    p_ovr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && rx_en) |=> overrun);

    // R6: disabling clears the flag
    p_ovr_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> !overrun);
endmodule

// File: tb/tb_addr_serial_rx.sv
module tb_addr_serial_rx;
    logic       clk = 0, rst_n = 0;
    logic       rx_en = 0, nine_bit = 0, addr_only = 0, tick = 0, rxd = 1, rd_pop = 0;
    logic [7:0] rd_data;
    logic       rd_bit9, rd_ferr, data_ready, overrun;

    int checks = 0, errors = 0;
    logic [9:0] expq[$];
    bit ovr_m = 0;

    localparam int BITCLK = 64;

    addr_serial_rx dut (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .nine_bit(nine_bit),
        .addr_only(addr_only), .tick(tick), .rxd(rxd), .rd_pop(rd_pop),
        .rd_data(rd_data), .rd_bit9(rd_bit9), .rd_ferr(rd_ferr),
        .data_ready(data_ready), .overrun(overrun)
    );

    always #5 clk = ~clk;

    initial begin
        int div = 0;
        forever begin
            @(negedge clk);
            tick = (div == 3);
            div  = (div + 1) % 4;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [9:0] model_entry(input logic [8:0] v, input bit nine, input bit stop);
        return {~stop, nine & v[8], v[7:0]};
    endfunction

    function automatic bit model_keep(input logic [8:0] v, input bit nine, input bit filt);
        return !(nine && filt && !v[8]);
    endfunction

    task automatic model(input logic [8:0] v, input bit stop);
        if (model_keep(v, nine_bit, addr_only)) begin
            if (ovr_m) ;
            else if (expq.size() == 2) ovr_m = 1;
            else expq.push_back(model_entry(v, nine_bit, stop));
        end
    endtask

    task automatic send(input logic [8:0] v, input bit stop);
        int n = nine_bit ? 9 : 8;
        rxd = 0;
        repeat (BITCLK) @(negedge clk);
        for (int i = 0; i < n; i++) begin
            rxd = v[i];
            repeat (BITCLK) @(negedge clk);
        end
        rxd = stop;
        repeat (BITCLK) @(negedge clk);
        rxd = 1;
        repeat (stop ? BITCLK : 3 * BITCLK) @(negedge clk);
        model(v, stop);
    endtask

    task automatic pop();
        rd_pop = 1;
        @(negedge clk);
        rd_pop = 0;
        @(negedge clk);
    endtask

    task automatic drain(input string req);
        while (expq.size() > 0) begin
            logic [9:0] e = expq.pop_front();
            chk(data_ready === 1'b1, req, data_ready, 1);
            chk({rd_ferr, rd_bit9, rd_data} === e, req, {rd_ferr, rd_bit9, rd_data}, e);
            pop();
        end
        chk(data_ready === 1'b0, req, data_ready, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd1357);
        repeat (5) @(negedge clk);
        // R10 reset state
        chk(data_ready === 1'b0, "R10", data_ready, 0);
        chk(overrun === 1'b0, "R10", overrun, 0);
        rst_n = 1; rx_en = 1;
        repeat (BITCLK) @(negedge clk);

        // R1 and R4: 8-bit, two entries in order
        send(9'h0A5, 1); send(9'h03C, 1);
        drain("R1_R4");

        // R2: ninth bit
        nine_bit = 1;
        send(9'h155, 1); send(9'h0AA, 1);
        drain("R2");

        // R3: filter drops data chars, keeps address chars
        addr_only = 1;
        send(9'h011, 1);
        chk(data_ready === 1'b0, "R3 drop", data_ready, 0);
        send(9'h122, 1);
        drain("R3 keep");
        nine_bit = 0;
        send(9'h177, 1);
        drain("R3 8bit");
        addr_only = 0;

        // R7: framing error travels with the character
        send(9'h05A, 0); send(9'h0C3, 1);
        drain("R7");

        // R5 and R6: overrun
        send(9'h001, 1); send(9'h002, 1); send(9'h003, 1);
        chk(overrun === 1'b1, "R5 set", overrun, 1);
        send(9'h004, 1);
        chk(overrun === 1'b1, "R6 hold", overrun, 1);
        drain("R5 order");
        send(9'h005, 1);
        chk(data_ready === 1'b0, "R5 frozen", data_ready, 0);
        chk(overrun === 1'b1, "R6 hold", overrun, 1);
        rx_en = 0; @(negedge clk); rx_en = 1; @(negedge clk);
        ovr_m = 0;
        chk(overrun === 1'b0, "R6 clear", overrun, 0);
        send(9'h0E7, 1);
        drain("R6 resume");

        // R9: short glitch
        rxd = 0; repeat (8) @(negedge clk); rxd = 1;
        repeat (2 * BITCLK) @(negedge clk);
        chk(data_ready === 1'b0, "R9", data_ready, 0);
        send(9'h09D, 1);
        drain("R9 after");

        // R8: pop on empty ignored
        pop();
        chk(data_ready === 1'b0, "R8 empty pop", data_ready, 0);
        send(9'h0F0, 1); send(9'h00F, 1);
        pop();
        chk(data_ready === 1'b1, "R8 one left", data_ready, 1);
        void'(expq.pop_front());
        drain("R8");

        // random mix
        for (int it = 0; it < 40; it++) begin
            int nf = 1 + ($urandom % 2);
            nine_bit  = $urandom % 2;
            addr_only = $urandom % 2;
            for (int k = 0; k < nf; k++) begin
                logic [8:0] v = 9'($urandom);
                send(v, ($urandom % 8) != 0);
            end
            drain("R1_R2_R3_R7 random");
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule